// File: doc/BRIEF.md
# Front-Panel Bus Console Controller

This block connects a panel of pushbuttons, toggle switches, sixteen data switches and LED rows to a generic microprocessor bus. From the panel an operator can set a 16-bit pointer, and then read or write the memory location it names. To do this the console becomes bus master for a single transfer. The pointer can step forward automatically after each access. The same panel starts, single-steps and stops the processor, and it can force a processor reset.

The console also takes part in the processor's own bus cycles. When the device switch is on, two adjacent byte addresses show the data switches to software and accept bytes for the LED row. After a reset, the two reset-vector bytes that the processor fetches are supplied from the data switches, so execution begins at the switch setting. With the breakpoint switch on, the data switches act as a breakpoint address. The processor is halted after it runs a bus cycle at that address. The LED rows always show the last bus address, the last data byte and a status byte.

Top module: `panel_console`

## Requirements
- R1: Each pushbutton press gives exactly one command, however long the button is held. Buttons are synchronized to the clock before use.
- R2: A load press copies `sw_data_i` into the transfer pointer. The next panel transfer then places that value on `dma_addr_o`.
- R3: With `sw_inc_i` high, the pointer advances by one after each completed panel transfer. With `sw_inc_i` low, it keeps its value.
- R4: A read or write press raises `bus_req_o`. The transfer (`dma_addr_oe_o` high for exactly one cycle) takes place only while `bus_grant_i` is high. `bus_req_o` falls in the cycle after the transfer.
- R5: A panel read captures `bus_data_i` during the transfer. With `sw_dev_i` low, `led_data_o` shows the captured byte in bits 7:0, with bits 15:8 zero.
- R6: A panel write drives `sw_data_i[7:0]` on `dma_data_o` with `dma_wr_o` high.
- R7: With `sw_dev_i` high, a processor read at `IO_ADDR` returns `sw_data_i[15:8]` and a read at `IO_ADDR+1` returns `sw_data_i[7:0]`. Processor writes at these two addresses load the high and the low byte of a user LED word, and `led_data_o` shows that word. With `sw_dev_i` low, these reads get no response and these writes change nothing.
- R8: A reset press drives `cpu_reset_o` high for `RST_CYCLES` cycles and clears the pointer to zero.
- R9: After power-up or a reset press, a read at `VEC_ADDR` returns `sw_data_i[15:8]` and a read at `VEC_ADDR+1` returns `sw_data_i[7:0]`. This happens whatever the setting of `sw_dev_i`. After the low byte has been read, these addresses get no response.
- R10: The console comes out of reset with `cpu_halt_o` high. A go press with `sw_single_i` high releases the halt for exactly one processor bus cycle.
- R11: A go press with `sw_single_i` low releases the halt, and the processor then runs continuously.
- R12: With `sw_bkpt_i` high, a processor bus cycle whose address equals `sw_data_i` halts the processor after that cycle, and status bit 5 is set.
- R13: `led_addr_o` holds the address of the last bus cycle, whether from the processor or from the console. `led_stat_o` bits 0 to 7 are, in order: halted, reset active, bus request, transfer in progress, last processor cycle was a write, breakpoint stop, vector armed, single-step in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_load_i | input | 1 | Load-pointer pushbutton |
| btn_read_i | input | 1 | Panel read pushbutton |
| btn_write_i | input | 1 | Panel write pushbutton |
| btn_go_i | input | 1 | Go pushbutton |
| btn_reset_i | input | 1 | Processor reset pushbutton |
| sw_inc_i | input | 1 | Pointer auto-increment switch |
| sw_dev_i | input | 1 | I/O register enable switch |
| sw_single_i | input | 1 | 1 = single step, 0 = run |
| sw_bkpt_i | input | 1 | Breakpoint enable switch |
| sw_data_i | input | 16 | Address/data switches |
| bus_valid_i | input | 1 | Processor bus cycle active this clock |
| bus_we_i | input | 1 | Processor cycle is a write |
| bus_addr_i | input | 16 | Processor address bus |
| bus_data_i | input | 8 | Monitored data bus |
| bus_grant_i | input | 1 | Bus grant to the console |
| bus_req_o | output | 1 | Bus request from the console |
| dma_addr_o | output | 16 | Console transfer address |
| dma_addr_oe_o | output | 1 | Console drives the address bus |
| dma_data_o | output | 8 | Console write data |
| dma_rd_o | output | 1 | Console read strobe |
| dma_wr_o | output | 1 | Console write strobe |
| cpu_data_o | output | 8 | Read data returned to the processor |
| cpu_data_oe_o | output | 1 | Console answers the current processor read |
| cpu_halt_o | output | 1 | Processor halt |
| cpu_reset_o | output | 1 | Processor reset |
| led_addr_o | output | 16 | Address LEDs |
| led_data_o | output | 16 | Data LEDs |
| led_stat_o | output | 8 | Status LEDs |

## Verification
A wrong pointer value shows on `dma_addr_o` in the very next transfer cycle. The bench compares it against its own pointer model on every transfer. A stuck transfer state shows as `bus_req_o` that never falls, or as a transfer without grant, within one cycle of the grant. A fault in the run-control state shows on `cpu_halt_o` in the cycle after the processor bus cycle that should end a step or hit the breakpoint. The bench counts the processor cycles actually run, so a single extra cycle is caught. A wrong vector-armed or I/O-enable state shows on `cpu_data_oe_o` combinationally, in the same cycle as the processor read.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {DMA_IDLE, DMA_REQ, DMA_XFER} dma_state_e;
  typedef enum logic [1:0] {RUN_HALT, RUN_STEP, RUN_FREE} run_state_e;

  localparam int unsigned CMD_LOAD  = 0;
  localparam int unsigned CMD_READ  = 1;
  localparam int unsigned CMD_WRITE = 2;
  localparam int unsigned CMD_GO    = 3;
  localparam int unsigned CMD_RST   = 4;
  localparam int unsigned CMD_NUM   = 5;
endpackage

// File: rtl/pc_btn_sync.sv
module pc_btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], btn_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;

  // R1
  pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/pc_dma.sv
module pc_dma import pc_pkg::*; #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_load_i,
  input  logic              cmd_read_i,
  input  logic              cmd_write_i,
  input  logic              cmd_rst_i,
  input  logic              sw_inc_i,
  input  logic [ADDR_W-1:0] sw_data_i,
  input  logic              bus_grant_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic              dma_addr_oe_o,
  output logic [ADDR_W/2-1:0] dma_data_o,
  output logic              dma_rd_o,
  output logic              dma_wr_o
);
  localparam int unsigned DATA_W = ADDR_W / 2;

  dma_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              wr_q;
  logic              xfer;
  logic              start;

  assign start = (state_q == DMA_IDLE) && (cmd_read_i || cmd_write_i);
  assign xfer  = (state_q == DMA_XFER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DMA_IDLE: if (cmd_read_i || cmd_write_i) state_d = DMA_REQ;
      DMA_REQ:  if (bus_grant_i) state_d = DMA_XFER;
      DMA_XFER: state_d = DMA_IDLE;
      default:  state_d = DMA_IDLE;
    endcase
    if (cmd_rst_i) state_d = DMA_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DMA_IDLE;
      ptr_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_rst_i)
        ptr_q <= '0;
      else if ((state_q == DMA_IDLE) && cmd_load_i)
        ptr_q <= sw_data_i;
      else if (xfer && sw_inc_i)
        ptr_q <= ptr_q + 1'b1;
      if (start) wr_q <= cmd_write_i;
    end
  end

  assign bus_req_o     = (state_q != DMA_IDLE);
  assign dma_addr_oe_o = xfer;
  assign dma_addr_o    = xfer ? ptr_q : '0;
  assign dma_rd_o      = xfer & ~wr_q;
  assign dma_wr_o      = xfer & wr_q;
  assign dma_data_o    = (xfer && wr_q) ? sw_data_i[DATA_W-1:0] : '0;

  // R4
  xfer_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_addr_oe_o |-> bus_grant_i);
  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_addr_oe_o && !cmd_rst_i) |=> !bus_req_o);
  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && sw_inc_i && !cmd_rst_i) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && !sw_inc_i && !cmd_rst_i) |=> $stable(ptr_q));
endmodule

// File: rtl/pc_run_ctl.sv
module pc_run_ctl import pc_pkg::*; #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_go_i,
  input  logic              sw_single_i,
  input  logic              sw_bkpt_i,
  input  logic [ADDR_W-1:0] sw_data_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              cpu_halt_o,
  output logic              stepping_o,
  output logic              bkpt_stop_o
);
  run_state_e state_q, state_d;
  logic       bkpt_q, bkpt_d;
  logic       bkpt_hit;

  assign bkpt_hit = sw_bkpt_i && bus_valid_i && (bus_addr_i == sw_data_i);

  always_comb begin
    state_d = state_q;
    bkpt_d  = bkpt_q;
    unique case (state_q)
      RUN_HALT: if (cmd_go_i) begin
        state_d = sw_single_i ? RUN_STEP : RUN_FREE;
        bkpt_d  = 1'b0;
      end
      RUN_STEP: if (bus_valid_i) begin
        state_d = RUN_HALT;
        bkpt_d  = bkpt_hit;
      end
      RUN_FREE: if (bkpt_hit) begin
        state_d = RUN_HALT;
        bkpt_d  = 1'b1;
      end
      default: state_d = RUN_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_HALT;
      bkpt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bkpt_q  <= bkpt_d;
    end
  end

  assign cpu_halt_o  = (state_q == RUN_HALT);
  assign stepping_o  = (state_q == RUN_STEP);
  assign bkpt_stop_o = bkpt_q;

  // R10
  step_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stepping_o && bus_valid_i) |=> cpu_halt_o);
  // R11
  free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == RUN_FREE) && !bkpt_hit) |=> !cpu_halt_o);
  // R12
  bkpt_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == RUN_FREE) && bkpt_hit) |=> (cpu_halt_o && bkpt_stop_o));
endmodule

// File: rtl/pc_bus_slave.sv
module pc_bus_slave #(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] IO_ADDR    = 16'hF000,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE,
  parameter int unsigned       RST_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_rst_i,
  input  logic                sw_dev_i,
  input  logic [ADDR_W-1:0]   sw_data_i,
  input  logic                bus_valid_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [ADDR_W/2-1:0] bus_data_i,
  output logic [ADDR_W/2-1:0] cpu_data_o,
  output logic                cpu_data_oe_o,
  output logic [ADDR_W-1:0]   led_user_o,
  output logic                cpu_reset_o,
  output logic                vec_armed_o
);
  localparam int unsigned DATA_W = ADDR_W / 2;
  localparam int unsigned CNT_W  = $clog2(RST_CYCLES + 1);

  logic             io_hit, vec_hit, rd_cyc, wr_cyc, vec_rd, io_rd, lo_sel;
  logic [CNT_W-1:0] rst_cnt_q;
  logic             armed_q;
  logic [ADDR_W-1:0] led_q;

  // pair of byte addresses: bit 0 picks low (1) or high (0) byte
  assign io_hit  = bus_addr_i[ADDR_W-1:1] == IO_ADDR[ADDR_W-1:1];
  assign vec_hit = bus_addr_i[ADDR_W-1:1] == VEC_ADDR[ADDR_W-1:1];
  assign lo_sel  = bus_addr_i[0];
  assign rd_cyc  = bus_valid_i & ~bus_we_i;
  assign wr_cyc  = bus_valid_i & bus_we_i;
  assign vec_rd  = rd_cyc & vec_hit & armed_q;
  assign io_rd   = rd_cyc & io_hit & sw_dev_i;

  assign cpu_data_oe_o = vec_rd | io_rd;
  assign cpu_data_o    = !cpu_data_oe_o ? '0 :
                         lo_sel ? sw_data_i[DATA_W-1:0] : sw_data_i[ADDR_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= '0;
      armed_q   <= 1'b1;
      led_q     <= '0;
    end else begin
      if (cmd_rst_i)
        rst_cnt_q <= CNT_W'(RST_CYCLES);
      else if (rst_cnt_q != '0)
        rst_cnt_q <= rst_cnt_q - 1'b1;

      if (cmd_rst_i || (rst_cnt_q != '0))
        armed_q <= 1'b1;
      else if (vec_rd && lo_sel)
        armed_q <= 1'b0;

      if (wr_cyc && io_hit && sw_dev_i) begin
        if (lo_sel) led_q[DATA_W-1:0]      <= bus_data_i;
        else        led_q[ADDR_W-1:DATA_W] <= bus_data_i;
      end
    end
  end

  assign cpu_reset_o = (rst_cnt_q != '0);
  assign vec_armed_o = armed_q;
  assign led_user_o  = led_q;

  // R7
  io_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_data_oe_o && !vec_hit) |-> sw_dev_i);
  // R7
  led_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_dev_i |=> $stable(led_user_o));
  // R8
  rst_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_i |=> cpu_reset_o);
  // R9
  vec_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && lo_sel && !cmd_rst_i && !cpu_reset_o) |=> !vec_armed_o);
endmodule

// File: rtl/panel_console.sv
module panel_console import pc_pkg::*; #(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IO_ADDR     = 16'hF000,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'hFFFE,
  parameter int unsigned       RST_CYCLES  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                btn_load_i,
  input  logic                btn_read_i,
  input  logic                btn_write_i,
  input  logic                btn_go_i,
  input  logic                btn_reset_i,
  input  logic                sw_inc_i,
  input  logic                sw_dev_i,
  input  logic                sw_single_i,
  input  logic                sw_bkpt_i,
  input  logic [ADDR_W-1:0]   sw_data_i,
  input  logic                bus_valid_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [ADDR_W/2-1:0] bus_data_i,
  input  logic                bus_grant_i,
  output logic                bus_req_o,
  output logic [ADDR_W-1:0]   dma_addr_o,
  output logic                dma_addr_oe_o,
  output logic [ADDR_W/2-1:0] dma_data_o,
  output logic                dma_rd_o,
  output logic                dma_wr_o,
  output logic [ADDR_W/2-1:0] cpu_data_o,
  output logic                cpu_data_oe_o,
  output logic                cpu_halt_o,
  output logic                cpu_reset_o,
  output logic [ADDR_W-1:0]   led_addr_o,
  output logic [ADDR_W-1:0]   led_data_o,
  output logic [7:0]          led_stat_o
);
  localparam int unsigned DATA_W = ADDR_W / 2;

  logic [CMD_NUM-1:0] btn_raw, cmd;
  logic               stepping, bkpt_stop, vec_armed;
  logic [ADDR_W-1:0]  led_user;
  logic [ADDR_W-1:0]  snoop_addr_q;
  logic [DATA_W-1:0]  snoop_data_q;
  logic               snoop_we_q;

  always_comb begin
    btn_raw           = '0;
    btn_raw[CMD_LOAD]  = btn_load_i;
    btn_raw[CMD_READ]  = btn_read_i;
    btn_raw[CMD_WRITE] = btn_write_i;
    btn_raw[CMD_GO]    = btn_go_i;
    btn_raw[CMD_RST]   = btn_reset_i;
  end

  for (genvar g = 0; g < CMD_NUM; g++) begin : g_btn
    pc_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .btn_i  (btn_raw[g]),
      .pulse_o(cmd[g])
    );
  end

  pc_dma #(.ADDR_W(ADDR_W)) u_dma (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_load_i   (cmd[CMD_LOAD]),
    .cmd_read_i   (cmd[CMD_READ]),
    .cmd_write_i  (cmd[CMD_WRITE]),
    .cmd_rst_i    (cmd[CMD_RST]),
    .sw_inc_i     (sw_inc_i),
    .sw_data_i    (sw_data_i),
    .bus_grant_i  (bus_grant_i),
    .bus_req_o    (bus_req_o),
    .dma_addr_o   (dma_addr_o),
    .dma_addr_oe_o(dma_addr_oe_o),
    .dma_data_o   (dma_data_o),
    .dma_rd_o     (dma_rd_o),
    .dma_wr_o     (dma_wr_o)
  );

  pc_run_ctl #(.ADDR_W(ADDR_W)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_go_i   (cmd[CMD_GO]),
    .sw_single_i(sw_single_i),
    .sw_bkpt_i  (sw_bkpt_i),
    .sw_data_i  (sw_data_i),
    .bus_valid_i(bus_valid_i),
    .bus_addr_i (bus_addr_i),
    .cpu_halt_o (cpu_halt_o),
    .stepping_o (stepping),
    .bkpt_stop_o(bkpt_stop)
  );

  pc_bus_slave #(
    .ADDR_W    (ADDR_W),
    .IO_ADDR   (IO_ADDR),
    .VEC_ADDR  (VEC_ADDR),
    .RST_CYCLES(RST_CYCLES)
  ) u_slave (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_rst_i    (cmd[CMD_RST]),
    .sw_dev_i     (sw_dev_i),
    .sw_data_i    (sw_data_i),
    .bus_valid_i  (bus_valid_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_data_i   (bus_data_i),
    .cpu_data_o   (cpu_data_o),
    .cpu_data_oe_o(cpu_data_oe_o),
    .led_user_o   (led_user),
    .cpu_reset_o  (cpu_reset_o),
    .vec_armed_o  (vec_armed)
  );

  // bus monitor for the display; console transfers take precedence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snoop_addr_q <= '0;
      snoop_data_q <= '0;
      snoop_we_q   <= 1'b0;
    end else if (dma_addr_oe_o) begin
      snoop_addr_q <= dma_addr_o;
      snoop_data_q <= dma_rd_o ? bus_data_i : dma_data_o;
    end else if (bus_valid_i) begin
      snoop_addr_q <= bus_addr_i;
      snoop_data_q <= bus_data_i;
      snoop_we_q   <= bus_we_i;
    end
  end

  assign led_addr_o = snoop_addr_q;
  assign led_data_o = sw_dev_i ? led_user : {{(ADDR_W-DATA_W){1'b0}}, snoop_data_q};
  assign led_stat_o = {stepping, vec_armed, bkpt_stop, snoop_we_q,
                       dma_addr_oe_o, bus_req_o, cpu_reset_o, cpu_halt_o};

  // R13
  snoop_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_addr_oe_o |=> (led_addr_o == $past(dma_addr_o)));
  // R5
  snoop_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rd_o |=> (snoop_data_q == $past(bus_data_i)));
endmodule

// File: tb/panel_console_bench.sv
`timescale 1ns/1ps
module panel_console_bench;
  import pc_pkg::*;

  localparam int RST_CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  btns = '0;
  logic        sw_inc = 1'b0, sw_dev = 1'b0, sw_single = 1'b0, sw_bkpt = 1'b0;
  logic [15:0] sw_data = '0;
  logic        bus_valid = 1'b0, bus_we = 1'b0, bus_grant = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data, cpu_wdata = '0;
  logic        bus_req, dma_oe, dma_rd, dma_wr, cpu_oe, cpu_halt, cpu_reset;
  logic [15:0] dma_addr, led_addr, led_data;
  logic [7:0]  dma_data, cpu_rdata, led_stat;

  always #2 clk = ~clk;

  panel_console u_panel_console (
    .clk_i(clk), .rst_ni(rst_n),
    .btn_load_i(btns[CMD_LOAD]), .btn_read_i(btns[CMD_READ]),
    .btn_write_i(btns[CMD_WRITE]), .btn_go_i(btns[CMD_GO]),
    .btn_reset_i(btns[CMD_RST]),
    .sw_inc_i(sw_inc), .sw_dev_i(sw_dev), .sw_single_i(sw_single),
    .sw_bkpt_i(sw_bkpt), .sw_data_i(sw_data),
    .bus_valid_i(bus_valid), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_data_i(bus_data), .bus_grant_i(bus_grant),
    .bus_req_o(bus_req), .dma_addr_o(dma_addr), .dma_addr_oe_o(dma_oe),
    .dma_data_o(dma_data), .dma_rd_o(dma_rd), .dma_wr_o(dma_wr),
    .cpu_data_o(cpu_rdata), .cpu_data_oe_o(cpu_oe),
    .cpu_halt_o(cpu_halt), .cpu_reset_o(cpu_reset),
    .led_addr_o(led_addr), .led_data_o(led_data), .led_stat_o(led_stat)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign bus_data = dma_rd ? mem_val(dma_addr) : cpu_wdata;

  // behavioural model state
  logic [15:0] ptr_m = '0;
  int          xfer_cnt = 0, rst_hi_cnt = 0, exec_cnt = 0, gnt_lat = 2, gnt_wait = 0;
  logic [15:0] last_xfer_addr = '0, pc_m = '0, last_exec = '0;
  logic [7:0]  last_wdata = '0;
  bit          last_was_wr = 0, cpu_auto = 0, auto_cyc = 0;
  bit          dir_valid = 0, dir_we = 0;
  logic [15:0] dir_addr = '0;
  logic [7:0]  dir_wdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      // account for the cycle that ended at the last rising edge
      if (auto_cyc && bus_valid) begin
        exec_cnt++;
        last_exec = bus_addr;
        pc_m = pc_m + 16'd1;
      end
      if (cpu_reset) rst_hi_cnt++;
      if (dma_oe) begin
        check(dma_addr == ptr_m, "R2/R3 transfer address vs pointer model", dma_addr, ptr_m);
        check(bus_grant, "R4 transfer only with grant", bus_grant, 1);
        xfer_cnt++;
        last_xfer_addr = dma_addr;
        last_was_wr = dma_wr;
        if (dma_wr) last_wdata = dma_data;
        if (sw_inc) ptr_m = ptr_m + 16'd1;
      end
    end
    // arbiter model
    if (bus_req) begin
      if (gnt_wait >= gnt_lat) bus_grant = 1'b1;
      else gnt_wait++;
    end else begin
      bus_grant = 1'b0;
      gnt_wait = 0;
    end
    // processor model
    if (dir_valid) begin
      bus_valid = 1'b1; bus_we = dir_we; bus_addr = dir_addr; cpu_wdata = dir_wdata; auto_cyc = 0;
    end else if (cpu_auto && !cpu_halt && !cpu_reset && !bus_grant) begin
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = pc_m; cpu_wdata = 8'h00; auto_cyc = 1;
    end else begin
      bus_valid = 1'b0; bus_we = 1'b0; auto_cyc = 0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic press(input int idx, input int hold);
    @(negedge clk); btns[idx] = 1'b1;
    repeat (hold) @(negedge clk);
    btns[idx] = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic proc_acc(input bit we, input logic [15:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output bit oe);
    @(posedge clk);
    dir_valid = 1; dir_we = we; dir_addr = a; dir_wdata = wd;
    @(negedge clk); #1;
    rd = cpu_rdata; oe = cpu_oe;
    @(posedge clk);
    dir_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  logic [7:0] rd;
  bit         oe;
  int         n0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    check(cpu_halt == 1'b1, "R10 halted after reset", cpu_halt, 1);
    check(bus_req == 1'b0, "R4 no request after reset", bus_req, 0);
    check(led_stat == 8'h41, "R13 status after reset", led_stat, 8'h41);

    // load pointer, read with a long press
    sw_data = 16'h1234; sw_inc = 1'b1; gnt_lat = 5;
    press(CMD_LOAD, 3);
    ptr_m = 16'h1234;
    n0 = xfer_cnt;
    press(CMD_READ, 20);
    check(xfer_cnt == n0 + 1, "R1 one transfer per long press", xfer_cnt - n0, 1);
    check(last_xfer_addr == 16'h1234, "R2 loaded address used", last_xfer_addr, 16'h1234);
    check(led_data == {8'h00, mem_val(16'h1234)}, "R5 read data on LEDs", led_data, {8'h00, mem_val(16'h1234)});
    check(led_addr == 16'h1234, "R13 address LEDs after transfer", led_addr, 16'h1234);

    // increment on
    press(CMD_READ, 2);
    check(last_xfer_addr == 16'h1235, "R3 pointer advanced", last_xfer_addr, 16'h1235);

    // increment off
    sw_inc = 1'b0;
    press(CMD_READ, 2);
    press(CMD_READ, 2);
    check(last_xfer_addr == 16'h1236, "R3 pointer held", last_xfer_addr, 16'h1236);

    // request held until a slow grant
    gnt_lat = 12; n0 = xfer_cnt;
    @(negedge clk); btns[CMD_READ] = 1'b1;
    while (!bus_req) @(negedge clk);
    repeat (6) @(negedge clk);
    check(bus_req == 1'b1, "R4 request held awaiting grant", bus_req, 1);
    check(xfer_cnt == n0, "R4 no transfer before grant", xfer_cnt - n0, 0);
    while (xfer_cnt == n0) @(negedge clk);
    check(bus_req == 1'b0, "R4 request released after one transfer", bus_req, 0);
    btns[CMD_READ] = 1'b0;
    repeat (10) @(negedge clk);
    check(xfer_cnt == n0 + 1, "R4 single transfer", xfer_cnt - n0, 1);
    gnt_lat = 2;

    // panel write
    sw_data = 16'h00A7;
    press(CMD_WRITE, 2);
    check(last_was_wr && last_wdata == 8'hA7, "R6 write data from switches", {last_was_wr, last_wdata}, 9'h1A7);

    // processor-visible registers
    sw_dev = 1'b1; sw_data = 16'hBEEF;
    proc_acc(0, 16'hF000, 8'h00, rd, oe);
    check(oe && rd == 8'hBE, "R7 high switch byte", {oe, rd}, 9'h1BE);
    proc_acc(0, 16'hF001, 8'h00, rd, oe);
    check(oe && rd == 8'hEF, "R7 low switch byte", {oe, rd}, 9'h1EF);
    proc_acc(1, 16'hF000, 8'h3C, rd, oe);
    proc_acc(1, 16'hF001, 8'h5A, rd, oe);
    check(led_data == 16'h3C5A, "R7 user LED word", led_data, 16'h3C5A);
    sw_dev = 1'b0;
    proc_acc(0, 16'hF000, 8'h00, rd, oe);
    check(oe == 1'b0, "R7 no response when disabled", oe, 0);
    proc_acc(1, 16'hF000, 8'h99, rd, oe);
    sw_dev = 1'b1;
    @(negedge clk);
    check(led_data == 16'h3C5A, "R7 write ignored when disabled", led_data, 16'h3C5A);
    sw_dev = 1'b0;

    // reset button
    rst_hi_cnt = 0;
    press(CMD_RST, 2);
    check(rst_hi_cnt == RST_CYC, "R8 reset pulse length", rst_hi_cnt, RST_CYC);
    ptr_m = 16'h0000;
    press(CMD_READ, 2);
    check(last_xfer_addr == 16'h0000, "R8 pointer cleared", last_xfer_addr, 0);

    // reset vector
    sw_data = 16'h2468;
    proc_acc(0, 16'hFFFE, 8'h00, rd, oe);
    check(oe && rd == 8'h24, "R9 vector high byte", {oe, rd}, 9'h124);
    proc_acc(0, 16'hFFFF, 8'h00, rd, oe);
    check(oe && rd == 8'h68, "R9 vector low byte", {oe, rd}, 9'h168);
    proc_acc(0, 16'hFFFE, 8'h00, rd, oe);
    check(oe == 1'b0, "R9 vector disarmed", oe, 0);

    // single step
    pc_m = 16'h0100; exec_cnt = 0; cpu_auto = 1; sw_single = 1'b1;
    press(CMD_GO, 2);
    check(exec_cnt == 1 && cpu_halt, "R10 one cycle per step", exec_cnt, 1);
    press(CMD_GO, 2);
    check(exec_cnt == 2 && last_exec == 16'h0101, "R10 second step", {exec_cnt[15:0], last_exec}, {16'd2, 16'h0101});

    // run to breakpoint
    sw_single = 1'b0; sw_bkpt = 1'b1; sw_data = 16'h0180;
    press(CMD_GO, 2);
    check(!cpu_halt && exec_cnt > 2, "R11 running continuously", {cpu_halt, exec_cnt[15:0]}, 0);
    repeat (200) @(negedge clk);
    check(cpu_halt, "R12 halted at breakpoint", cpu_halt, 1);
    check(last_exec == 16'h0180, "R12 last cycle at breakpoint", last_exec, 16'h0180);
    check(exec_cnt == 129, "R11 cycle count to breakpoint", exec_cnt, 129);
    check(led_addr == 16'h0180, "R13 address LEDs follow processor", led_addr, 16'h0180);
    check(led_stat == 8'h21, "R12 status breakpoint bit", led_stat, 8'h21);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule